// File: doc/BRIEF.md
# Nine-bit asynchronous serial port with control/status byte

This block is a full-duplex asynchronous serial port. It transmits and receives characters made of a low start bit, eight data bits sent least significant bit first, an optional ninth bit, and one high stop bit. When a ninth bit is present, it carries either a software-chosen extra bit or a parity bit. Bit timing comes from an external tick input that pulses sixteen times per bit period. The block does not generate the baud rate itself.

Received characters are held in a small queue, two entries deep by default, and the host pops them from that queue. Software controls the port through one 8-bit control/status byte, which is read and written over a simple register port. Four of its bits are flags that only hardware can set and only a software write of 0 can clear. A single interrupt request output is high while either the transmit or the receive event flag is set.

Top module: `uart9_csr`

## Requirements
- R1: After reset the control/status byte reads 0x20. Bit 5 always reads 1, and writes to bit 5 are ignored.
- R2: The flags are overrun (bit 7), parity error (bit 6), transmit event (bit 1) and receive event (bit 0). Writing 0 to a flag bit clears it. Writing 1 to a flag bit leaves it unchanged. Bits 4 (receive enable), 3 (transmit extra bit) and 2 (receive extra bit) take the value written to them.
- R3: The line idles high. A pulse on `tx_strobe` while the transmitter is idle sends one frame: a start bit of 0, `tx_data` least significant bit first, an optional ninth bit, and a stop bit of 1. Each bit lasts 16 ticks. A strobe that arrives while a frame is in progress is ignored.
- R4: A ninth bit is present when `xbit_en` or `par_en` is 1. With `par_en`=1, the ninth bit is the parity bit: the XOR of the data bits XOR `par_odd` (so `par_odd`=1 gives odd parity over all nine bits). With `par_en`=0 and `xbit_en`=1, the ninth bit is register bit 3.
- R5: The transmit event flag sets on the same clock edge on which the line enters the stop bit.
- R6: The receiver detects a falling edge, confirms the line is still low half a bit later, and then samples each bit 16 ticks after the previous sample. When the stop bit is sampled, the receive event flag sets and the character joins a 2-entry queue. `rx_data` shows the oldest entry, `rx_avail` is 1 while the queue is not empty, and `rx_pop` removes the oldest entry.
- R7: A character that completes while the queue is full is discarded and sets the overrun flag. The flag stays set until software writes 0 to bit 7.
- R8: With `par_en`=1, the parity error flag sets when a character whose parity does not match becomes the oldest queued entry.
- R9: With receive enable at 0, no new frame is accepted, but queued bytes can still be popped.
- R10: At the end of each received frame, bit 2 is loaded with the received ninth bit when `xbit_en`=1, or with the stop-bit level when `xbit_en`=0.
- R11: `irq` is 1 exactly while the transmit or the receive event flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick16 | input | 1 | Oversampling tick, 16 per bit |
| xbit_en | input | 1 | Ninth bit carries the extra bit |
| par_en | input | 1 | Ninth bit carries parity |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| reg_wr | input | 1 | Control/status byte write strobe |
| reg_wdata | input | 8 | Control/status write data |
| reg_rdata | output | 8 | Control/status byte |
| tx_strobe | input | 1 | Start a transmit frame |
| tx_data | input | 8 | Byte to transmit |
| tx_busy | output | 1 | Frame in progress |
| rx_pop | input | 1 | Remove the oldest received byte |
| rx_data | output | 8 | Oldest received byte |
| rx_avail | output | 1 | Queue not empty |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a parity error that stays hidden behind a good byte. The error must appear only when the bad byte becomes the oldest queued entry, and not when it arrives. The bench drives a correct-parity frame followed by a wrong-parity frame. It checks that the flag stays clear, then pops once and checks that the flag sets.

The bench fills the queue with three frames and no pops, which produces an overrun. It then drains the queue to show that the third byte was lost. It also sends a frame whose stop bit is 0, to show that the stop level is captured into bit 2.

// File: rtl/uart9_csr.sv
module uart9_csr #(
  parameter int FIFO_DEPTH = 2,
  parameter int OVS        = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       xbit_en,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       rxd,
  output logic       txd,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       tx_strobe,
  input  logic [7:0] tx_data,
  output logic       tx_busy,
  input  logic       rx_pop,
  output logic [7:0] rx_data,
  output logic       rx_avail,
  output logic       irq
);
  localparam int AW   = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CW   = $clog2(FIFO_DEPTH + 1) + 1;
  localparam int TW   = $clog2(OVS);
  localparam int HALF = OVS / 2 - 1;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_st_t;

  logic ovr, perr, ren, tbx, rbx, ti, ri;
  logic unused_bit5;
  assign unused_bit5 = reg_wdata[5];

  wire nine_on = xbit_en | par_en;

  // transmitter
  logic [10:0]   tx_sh;
  logic [3:0]    tx_idx;
  logic [TW-1:0] tx_tc;
  wire  [3:0]    tx_nb   = nine_on ? 4'd11 : 4'd10;
  wire           tx_nine = par_en ? (^tx_data ^ par_odd) : tbx;
  wire           tx_go   = tx_strobe && !tx_busy;
  wire           tx_step = tx_busy && tick16 && (tx_tc == TW'(OVS - 1));
  wire           ti_set  = tx_step && (tx_idx + 4'd1 == tx_nb - 4'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_busy <= 1'b0;
      tx_sh   <= '1;
      tx_idx  <= '0;
      tx_tc   <= '0;
    end else if (tx_go) begin
      tx_busy <= 1'b1;
      tx_sh   <= nine_on ? {1'b1, tx_nine, tx_data, 1'b0} : {2'b11, tx_data, 1'b0};
      tx_idx  <= '0;
      tx_tc   <= '0;
    end else if (tx_busy && tick16) begin
      if (tx_step) begin
        tx_tc  <= '0;
        tx_sh  <= {1'b1, tx_sh[10:1]};
        tx_idx <= tx_idx + 4'd1;
        if (tx_idx + 4'd1 == tx_nb) tx_busy <= 1'b0;
      end else begin
        tx_tc <= tx_tc + TW'(1);
      end
    end
  end

  assign txd = tx_busy ? tx_sh[0] : 1'b1;

  // receiver
  rx_st_t        rx_st;
  logic [2:0]    rx_sync;
  logic [TW-1:0] rx_tc;
  logic [3:0]    rx_idx;
  logic [8:0]    rx_buf;
  wire           rx_s    = rx_sync[1];
  wire           rx_q    = rx_sync[2];
  wire  [3:0]    rx_nb   = nine_on ? 4'd9 : 4'd8;
  wire           rx_done = (rx_st == RX_BITS) && tick16 && (rx_tc == TW'(OVS - 1)) && (rx_idx == rx_nb);
  wire  [8:0]    rx_word = {nine_on ? rx_buf[8] : 1'b0, rx_buf[7:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sync <= 3'b111;
      rx_st   <= RX_IDLE;
      rx_tc   <= '0;
      rx_idx  <= '0;
      rx_buf  <= '0;
    end else begin
      rx_sync <= {rx_sync[1:0], rxd};
      case (rx_st)
        RX_IDLE:
          if (ren && rx_q && !rx_s) begin
            rx_st <= RX_START;
            rx_tc <= '0;
          end
        RX_START:
          if (tick16) begin
            if (rx_tc == TW'(HALF)) begin
              rx_tc  <= '0;
              rx_idx <= '0;
              rx_st  <= rx_s ? RX_IDLE : RX_BITS;
            end else begin
              rx_tc <= rx_tc + TW'(1);
            end
          end
        RX_BITS:
          if (tick16) begin
            if (rx_tc == TW'(OVS - 1)) begin
              rx_tc <= '0;
              if (rx_idx == rx_nb) begin
                rx_st <= RX_IDLE;
              end else begin
                rx_buf[rx_idx] <= rx_s;
                rx_idx         <= rx_idx + 4'd1;
              end
            end else begin
              rx_tc <= rx_tc + TW'(1);
            end
          end
        default: rx_st <= RX_IDLE;
      endcase
    end
  end

  // receive queue
  logic [8:0]    fq [FIFO_DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(FIFO_DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  function automatic logic bad_par(input logic [8:0] w, input logic odd);
    return (^w[7:0] ^ w[8]) != odd;
  endfunction

  wire f_empty   = (cnt == '0);
  wire f_full    = (cnt == CW'(FIFO_DEPTH));
  wire push      = rx_done && !f_full;
  wire pop       = rx_pop && !f_empty;
  wire ovr_set   = rx_done && f_full;
  wire head_q    = pop && (cnt >= CW'(2));
  wire head_in   = push && (f_empty || (cnt == CW'(1) && pop));
  wire perr_set  = par_en && ((head_q && bad_par(fq[nxt(rp)], par_odd)) ||
                              (head_in && bad_par(rx_word, par_odd)));

  always_ff @(posedge clk) if (push) fq[wp] <= rx_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop)  rp <= nxt(rp);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  assign rx_data  = fq[rp][7:0];
  assign rx_avail = !f_empty;

  // control/status byte
  wire clr7 = reg_wr && !reg_wdata[7];
  wire clr6 = reg_wr && !reg_wdata[6];
  wire clr1 = reg_wr && !reg_wdata[1];
  wire clr0 = reg_wr && !reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr <= 1'b0; perr <= 1'b0; ren <= 1'b0; tbx <= 1'b0;
      rbx <= 1'b0; ti   <= 1'b0; ri  <= 1'b0;
    end else begin
      ovr  <= ovr_set  | (ovr  & ~clr7);
      perr <= perr_set | (perr & ~clr6);
      ti   <= ti_set   | (ti   & ~clr1);
      ri   <= rx_done  | (ri   & ~clr0);
      if (reg_wr) begin
        ren <= reg_wdata[4];
        tbx <= reg_wdata[3];
        rbx <= reg_wdata[2];
      end
      if (rx_done) rbx <= xbit_en ? rx_buf[8] : rx_s;
    end
  end

  assign reg_rdata = {ovr, perr, 1'b1, ren, tbx, rbx, ti, ri};
  assign irq       = ti | ri;

  AST_START_LOW:  assert property (@(posedge clk) disable iff (!rst_n) tx_busy && tx_idx == 4'd0 |-> !txd); // R3
  AST_TX_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) tx_busy && tx_strobe && !tick16 |=> $stable(tx_sh)); // R3
  AST_TI_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n) $rose(ti) |-> tx_busy && txd); // R5
  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(FIFO_DEPTH)); // R6
  AST_FULL_DROP:  assert property (@(posedge clk) disable iff (!rst_n) rx_done && f_full && !rx_pop |=> $stable(cnt)); // R7
  AST_OVR_HOLDS:  assert property (@(posedge clk) disable iff (!rst_n) ovr && !clr7 |=> ovr); // R7
  AST_PERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) perr && !clr6 |=> perr); // R8
  AST_REN_GATES:  assert property (@(posedge clk) disable iff (!rst_n) rx_st == RX_IDLE && !ren |=> rx_st == RX_IDLE); // R9
endmodule

// File: tb/tb_uart9_csr.sv
module tb_uart9_csr;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, tick16 = 1;
  logic xb = 0, pe = 0, po = 0, rxd = 1;
  logic reg_wr = 0, tx_strobe = 0, rx_pop = 0;
  logic [7:0] reg_wdata = 0, tx_data = 0;
  logic txd, tx_busy, rx_avail, irq;
  logic [7:0] reg_rdata, rx_data;
  int n_chk = 0, n_bad = 0;
  logic ren_v = 0, tbx_v = 0;

  uart9_csr dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .xbit_en(xb), .par_en(pe), .par_odd(po),
    .rxd(rxd), .txd(txd), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_strobe(tx_strobe), .tx_data(tx_data), .tx_busy(tx_busy), .rx_pop(rx_pop),
    .rx_data(rx_data), .rx_avail(rx_avail), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk); reg_wr = 1; reg_wdata = v;
    @(negedge clk); reg_wr = 0;
  endtask

  // keep: flags that must stay as they are (bit set = keep)
  function automatic logic [7:0] ctl(input logic [7:0] keep);
    return keep | {3'b000, ren_v, tbx_v, 3'b000};
  endfunction

  task automatic pop();
    @(negedge clk); rx_pop = 1;
    @(negedge clk); rx_pop = 0;
  endtask

  function automatic logic exp_tx_bit(input int i, input logic [7:0] d);
    int nb = (xb | pe) ? 11 : 10;
    if (i == 0) return 1'b0;
    if (i <= 8) return d[i-1];
    if (i == nb - 1) return 1'b1;
    return pe ? (^d ^ po) : tbx_v;
  endfunction

  task automatic tx_frame(input logic [7:0] d);
    int nb = (xb | pe) ? 11 : 10;
    @(negedge clk); tx_strobe = 1; tx_data = d;
    @(posedge clk);
    @(negedge clk); tx_strobe = 0;
    for (int i = 0; i < nb; i++) begin
      repeat (8) @(negedge clk);
      chk($sformatf("R3/R4 tx bit %0d of %02h", i, d), txd, exp_tx_bit(i, d));
      if (i == nb - 2) chk("R5 ti before stop", reg_rdata[1], 0);
      if (i == nb - 1) begin
        chk("R5 ti at stop", reg_rdata[1], 1);
        chk("R11 irq with ti", irq, 1);
      end
      if (i == 3) begin
        tx_strobe = 1; tx_data = ~d;  // R3: ignored mid-frame
        @(negedge clk); tx_strobe = 0;
        repeat (7) @(negedge clk);
      end else begin
        repeat (8) @(negedge clk);
      end
    end
    chk("R3 idle after frame", {tx_busy, txd}, 2'b01);
    wr(ctl(8'hC1));
    chk("R2 ti cleared", reg_rdata[1], 0);
    chk("R11 irq low", irq, 0);
  endtask

  task automatic rx_frame(input logic [7:0] d, input logic has9, input logic b9, input logic stopv);
    @(negedge clk); rxd = 0; repeat (15) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rxd = d[i]; repeat (16) @(negedge clk); end
    if (has9) begin rxd = b9; repeat (16) @(negedge clk); end
    rxd = stopv; repeat (16) @(negedge clk);
    rxd = 1; repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic b9;
    repeat (3) @(negedge clk);
    chk("R1 reset value", reg_rdata, 8'h20);
    chk("R11 irq reset", irq, 0);
    chk("R3 idle line", txd, 1);
    rst_n = 1;
    wr(8'hFF);
    chk("R1 R2 write ones", reg_rdata, 8'h3C);
    wr(8'h00);
    chk("R1 bit5 stays", reg_rdata, 8'h20);
    ren_v = 1;
    wr(ctl(8'h00));

    // transmit sweep over four ninth-bit modes
    for (int m = 0; m < 4; m++) begin
      xb = (m == 1); pe = (m >= 2); po = (m == 3);
      for (int k = 0; k < 16; k++) begin
        d = 8'(k * 17 + m);
        tbx_v = k[0];
        wr(ctl(8'h00));
        tx_frame(d);
      end
    end
    tbx_v = 0;

    // receive sweep
    for (int m = 0; m < 4; m++) begin
      xb = (m == 1); pe = (m >= 2); po = (m == 3);
      for (int k = 0; k < 16; k++) begin
        d = 8'(k * 29 + 3 * m);
        b9 = pe ? (^d ^ po) : ~d[0];
        rx_frame(d, xb | pe, b9, 1'b1);
        chk("R6 ri set", reg_rdata[0], 1);
        chk("R11 irq with ri", irq, 1);
        chk("R6 avail", rx_avail, 1);
        chk($sformatf("R6 data %02h", d), rx_data, d);
        if (m == 0) chk("R10 rbx stop level", reg_rdata[2], 1);
        if (m == 1) chk("R10 rbx ninth", reg_rdata[2], b9);
        chk("R8 no parity error", reg_rdata[6], 0);
        pop();
        chk("R6 empty after pop", rx_avail, 0);
        wr(ctl(8'h00));
        chk("R2 ri cleared", reg_rdata[0], 0);
      end
    end

    // stop level captured when no extra bit
    xb = 0; pe = 0; po = 0;
    rx_frame(8'h5A, 0, 0, 1'b0);
    chk("R10 rbx takes stop 0", reg_rdata[2], 0);
    chk("R6 data with bad stop", rx_data, 8'h5A);
    pop(); wr(ctl(8'h00));

    // parity error on oldest byte
    pe = 1; po = 0;
    rx_frame(8'h03, 1, 1'b0, 1'b1);
    rx_frame(8'h07, 1, 1'b0, 1'b1);
    chk("R8 good head, no error", reg_rdata[6], 0);
    pop();
    chk("R8 bad byte now oldest", reg_rdata[6], 1);
    chk("R8 data", rx_data, 8'h07);
    wr(ctl(8'h40));
    chk("R2 perr kept by write 1", reg_rdata[6], 1);
    wr(ctl(8'h00));
    chk("R2 perr cleared", reg_rdata[6], 0);
    pop();
    rx_frame(8'h01, 1, 1'b0, 1'b1);
    chk("R8 bad into empty", reg_rdata[6], 1);
    pop(); wr(ctl(8'h00));
    pe = 0;

    // overrun
    rx_frame(8'h11, 0, 0, 1);
    rx_frame(8'h22, 0, 0, 1);
    chk("R7 full, no overrun", reg_rdata[7], 0);
    rx_frame(8'h33, 0, 0, 1);
    chk("R7 overrun set", reg_rdata[7], 1);
    chk("R7 oldest kept", rx_data, 8'h11);
    pop();
    chk("R7 second kept", rx_data, 8'h22);
    pop();
    chk("R7 third dropped", rx_avail, 0);
    wr(ctl(8'h80));
    chk("R2 ovr kept by write 1", reg_rdata[7], 1);
    wr(ctl(8'h00));
    chk("R7 ovr cleared", reg_rdata[7], 0);

    // receive disabled
    rx_frame(8'h44, 0, 0, 1);
    wr(ctl(8'h00));
    ren_v = 0; wr(ctl(8'h00));
    rx_frame(8'h55, 0, 0, 1);
    chk("R9 no ri while off", reg_rdata[0], 0);
    chk("R9 queued byte readable", rx_data, 8'h44);
    pop();
    chk("R9 nothing new queued", rx_avail, 0);
    ren_v = 1; wr(ctl(8'h00));
    rx_frame(8'h66, 0, 0, 1);
    chk("R9 enabled again", rx_data, 8'h66);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule